// File: doc/BRIEF.md
# Multi-Window Address Decoder with Translation

This block takes a 32-bit bus address and checks it against a set of address windows. Each window is described by four things: a base address, an address mask, a translation address and a three-bit control field. The decode is purely combinational. When an address hits a window, the block reports the winning window as a one-hot vector and as an index, together with that window's space type (memory or I/O), its prefetch and read-line attributes, and the outgoing address. The outgoing address is translated when the window has translation enabled.

Window 0 is fixed to a configuration region and cannot be changed. Windows 1 up to `NUM_WIN-1` are programmable through a single-cycle register write port, and a combinational read port returns what each window holds. Window slots from `NUM_WIN` up to the architectural maximum of six exist only as zeros. The bus handshake and the data path sit outside this block.

Top module: `addr_window_decoder`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, every programmable window is cleared to zero base, mask, translation and control. After reset only window 0 can hit.
- R2: A write with `wr_en` high changes the selected field of window `wr_win` at the next rising clock edge. The field codes for `wr_fld` and `rd_fld` are: 0 control, 1 base, 2 mask, 3 translation. `rd_data` shows the stored value of field `rd_fld` of window `rd_win` in the same cycle.
- R3: A window hits when its mask is non-zero and `(in_addr[31:12] & mask) == (base[31:12] & mask)`. A window whose mask is zero never hits.
- R4: `hit_vec` has at most one bit set, and that bit marks the lowest-numbered window that hits. `hit_idx` gives the number of that window, and `any_hit` is high exactly when some window hits. With no hit, `hit_vec` and `hit_idx` are zero.
- R5: When the winning window has control bit 0 (translate) set, `out_addr[31:12]` equals `(in_addr & ~mask) | (xlat & mask)` over bits 31:12. In every other case `out_addr[31:12]` equals `in_addr[31:12]`. `out_addr[11:0]` always equals `in_addr[11:0]`.
- R6: Window 0 always reads base `CFG_BASE` with bit 0 clear (memory), mask `CFG_MASK`, translation 0 and control 0. Writes to window 0 are ignored. An address that hits window 0 leaves the block untranslated, with all attributes low.
- R7: Window numbers from `NUM_WIN` to 7 read as zero in every field, ignore writes and never hit.
- R8: `hit_io` reflects base bit 0 of the winning window. `hit_prefetch` reflects control bit 1 and `hit_readline` reflects control bit 2. All three are low when nothing hits.
- R9: Base reads return bits 31:12 and bit 0 as written, with bits 11:1 zero. Mask and translation reads return bits 31:12 with bits 11:0 zero. Control reads return bits 2:0 with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window number to write |
| wr_fld | input | 2 | Field to write (0 ctrl, 1 base, 2 mask, 3 xlat) |
| wr_data | input | 32 | Write data |
| rd_win | input | 3 | Window number to read |
| rd_fld | input | 2 | Field to read |
| rd_data | output | 32 | Read data |
| in_addr | input | 32 | Incoming bus address |
| hit_vec | output | 6 | One-hot winning window |
| any_hit | output | 1 | Some window hit |
| hit_idx | output | 3 | Winning window number |
| hit_io | output | 1 | Winner is I/O space |
| hit_prefetch | output | 1 | Winner allows prefetch |
| hit_readline | output | 1 | Winner allows read-line |
| out_addr | output | 32 | Translated outgoing address |

## Verification
The bench programs two overlapping windows so that one address hits both. A decoder with the priority reversed would report the higher window and its translated address. It also gives a window a base that matches but a zero mask; a decoder without the non-zero-mask rule would claim every address for that window. Writes aimed at window 0 and at unimplemented slots are made, then read back. A decoder that stores them would return the written data or start hitting on those windows. Random traffic with addresses drawn near the programmed bases checks translation. If the low bits of an address leaked through the mask, or translation were applied with the enable bit clear, the outgoing address would no longer match the model.

// File: rtl/awd_pkg.sv
// Package: shared constants and field codes for the address window decoder.
// Assumes at most six windows; window 0 is the fixed configuration window.
package awd_pkg;
    localparam int MAX_WIN = 6;
    localparam int IDX_W   = 3;

    // Register field select codes used by the write and read ports
    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_BASE = 2'd1,
        FLD_MASK = 2'd2,
        FLD_XLAT = 2'd3
    } fld_e;

    // Bit positions inside the control field
    localparam int CTL_XLAT = 0;
    localparam int CTL_PREF = 1;
    localparam int CTL_RDLN = 2;
endpackage

// File: rtl/awd_window_regs.sv
// Module: storage for one programmable window (base page, space bit, mask,
// translation page, control). Assumes the caller has already qualified
// wr_sel with the window number; reset is synchronous active-low.
module awd_window_regs #(
    parameter int PG_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  logic [1:0]      wr_fld,
    input  logic [PG_W-1:0] wr_page,
    input  logic [2:0]      wr_low,
    output logic [PG_W-1:0] base_pg,
    output logic            is_io,
    output logic [PG_W-1:0] mask_pg,
    output logic [PG_W-1:0] xlat_pg,
    output logic [2:0]      ctrl
);
    import awd_pkg::*;

    // Update the addressed field on a write, clear everything on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_pg <= '0;
            is_io   <= 1'b0;
            mask_pg <= '0;
            xlat_pg <= '0;
            ctrl    <= '0;
        end else if (wr_sel) begin
            case (fld_e'(wr_fld))
                FLD_CTRL: ctrl <= wr_low;
                FLD_BASE: begin
                    base_pg <= wr_page;
                    is_io   <= wr_low[0];
                end
                FLD_MASK: mask_pg <= wr_page;
                FLD_XLAT: xlat_pg <= wr_page;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/awd_match.sv
// Module: page-level compare of an address against one window.
// Assumes a zero mask means the window is switched off.
module awd_match #(
    parameter int PG_W = 20
) (
    input  logic [PG_W-1:0] addr_pg,
    input  logic [PG_W-1:0] base_pg,
    input  logic [PG_W-1:0] mask_pg,
    output logic            hit
);
    // Masked equality, qualified by a live mask
    always_comb begin
        hit = (|mask_pg) && ((addr_pg & mask_pg) == (base_pg & mask_pg));
    end
endmodule

// File: rtl/awd_priority.sv
// Module: picks the lowest-numbered requester; gives one-hot grant and index.
// Assumes IW bits are enough to number N requesters.
module awd_priority #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest set request is assigned last
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/addr_window_decoder.sv
// Module: multi-window address decoder with per-window translation.
// Window 0 is a fixed configuration window; windows 1..NUM_WIN-1 are
// programmable; slots up to MAX_WIN-1 beyond that read as zero.
// Assumes 1 <= NUM_WIN <= MAX_WIN and a non-zero CFG_MASK page.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                PAGE_LSB = 12,
    parameter int                NUM_WIN  = 4,
    parameter logic [ADDR_W-1:0] CFG_BASE = 32'hC000_0000,
    parameter logic [ADDR_W-1:0] CFG_MASK = 32'hFFFF_F000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_win,
    input  logic [1:0]         wr_fld,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_win,
    input  logic [1:0]         rd_fld,
    output logic [ADDR_W-1:0]  rd_data,
    input  logic [ADDR_W-1:0]  in_addr,
    output logic [MAX_WIN-1:0] hit_vec,
    output logic               any_hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               hit_io,
    output logic               hit_prefetch,
    output logic               hit_readline,
    output logic [ADDR_W-1:0]  out_addr
);
    localparam int PG_W = ADDR_W - PAGE_LSB;
    localparam logic [PG_W-1:0] CFG_BASE_PG = CFG_BASE[ADDR_W-1:PAGE_LSB];
    localparam logic [PG_W-1:0] CFG_MASK_PG = CFG_MASK[ADDR_W-1:PAGE_LSB];

    logic [PG_W-1:0]    w_base [MAX_WIN];
    logic [PG_W-1:0]    w_mask [MAX_WIN];
    logic [PG_W-1:0]    w_xlat [MAX_WIN];
    logic               w_io   [MAX_WIN];
    logic [2:0]         w_ctrl [MAX_WIN];
    logic [MAX_WIN-1:0] w_hit;
    logic [PG_W-1:0]    addr_pg;
    logic               unused_wr_bits;

    assign addr_pg        = in_addr[ADDR_W-1:PAGE_LSB];
    assign unused_wr_bits = ^wr_data[PAGE_LSB-1:3];

    // One slot per architectural window: fixed, programmable or absent
    for (genvar g = 0; g < MAX_WIN; g++) begin : g_win
        if (g == 0) begin : g_cfg
            assign w_base[g] = CFG_BASE_PG;
            assign w_mask[g] = CFG_MASK_PG;
            assign w_xlat[g] = '0;
            assign w_io[g]   = 1'b0;
            assign w_ctrl[g] = '0;
        end else if (g < NUM_WIN) begin : g_prog
            logic sel;
            assign sel = wr_en && (wr_win == IDX_W'(g));
            awd_window_regs #(.PG_W(PG_W)) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_sel  (sel),
                .wr_fld  (wr_fld),
                .wr_page (wr_data[ADDR_W-1:PAGE_LSB]),
                .wr_low  (wr_data[2:0]),
                .base_pg (w_base[g]),
                .is_io   (w_io[g]),
                .mask_pg (w_mask[g]),
                .xlat_pg (w_xlat[g]),
                .ctrl    (w_ctrl[g])
            );
        end else begin : g_none
            assign w_base[g] = '0;
            assign w_mask[g] = '0;
            assign w_xlat[g] = '0;
            assign w_io[g]   = 1'b0;
            assign w_ctrl[g] = '0;
        end

        awd_match #(.PG_W(PG_W)) u_match (
            .addr_pg (addr_pg),
            .base_pg (w_base[g]),
            .mask_pg (w_mask[g]),
            .hit     (w_hit[g])
        );
    end

    awd_priority #(.N(MAX_WIN), .IW(IDX_W)) u_prio (
        .req   (w_hit),
        .grant (hit_vec),
        .idx   (hit_idx),
        .any   (any_hit)
    );

    logic [PG_W-1:0] sel_mask;
    logic [PG_W-1:0] sel_xlat;
    logic            sel_io;
    logic [2:0]      sel_ctrl;

    // AND-OR mux of the granted window's attributes
    always_comb begin
        sel_mask = '0;
        sel_xlat = '0;
        sel_io   = 1'b0;
        sel_ctrl = '0;
        for (int i = 0; i < MAX_WIN; i++) begin
            sel_mask = sel_mask | ({PG_W{hit_vec[i]}} & w_mask[i]);
            sel_xlat = sel_xlat | ({PG_W{hit_vec[i]}} & w_xlat[i]);
            sel_io   = sel_io   | (hit_vec[i] & w_io[i]);
            sel_ctrl = sel_ctrl | ({3{hit_vec[i]}} & w_ctrl[i]);
        end
    end

    // Translate the page bits when the winner enables it; offset passes
    always_comb begin
        logic [PG_W-1:0] out_pg;
        if (sel_ctrl[CTL_XLAT])
            out_pg = (addr_pg & ~sel_mask) | (sel_xlat & sel_mask);
        else
            out_pg = addr_pg;
        out_addr     = {out_pg, in_addr[PAGE_LSB-1:0]};
        hit_io       = sel_io;
        hit_prefetch = sel_ctrl[CTL_PREF];
        hit_readline = sel_ctrl[CTL_RDLN];
    end

    // Readback of one field of one window; absent numbers return zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < MAX_WIN; i++) begin
            if (rd_win == IDX_W'(i)) begin
                case (fld_e'(rd_fld))
                    FLD_CTRL: rd_data = {{(ADDR_W-3){1'b0}}, w_ctrl[i]};
                    FLD_BASE: rd_data = {w_base[i], {(PAGE_LSB-1){1'b0}}, w_io[i]};
                    FLD_MASK: rd_data = {w_mask[i], {PAGE_LSB{1'b0}}};
                    FLD_XLAT: rd_data = {w_xlat[i], {PAGE_LSB{1'b0}}};
                    default:  rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/awd_checker.sv
// Module: property checker for the address window decoder, bound to the top.
// Assumes the default window count and the shared package constants.
module awd_checker
    import awd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    parameter int NUM_WIN  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  in_addr,
    input logic [MAX_WIN-1:0] hit_vec,
    input logic               any_hit,
    input logic [IDX_W-1:0]   hit_idx,
    input logic               hit_io,
    input logic               hit_prefetch,
    input logic               hit_readline,
    input logic [ADDR_W-1:0]  out_addr
);
    localparam logic [MAX_WIN-1:0] IMPL_MASK = MAX_WIN'((1 << NUM_WIN) - 1);

    // R4
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R4
    hit_idx_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit_vec[hit_idx]);

    // R5
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr[PAGE_LSB-1:0] == in_addr[PAGE_LSB-1:0]);

    // R5
    nohit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> out_addr == in_addr);

    // R6
    cfg_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[0] |-> (out_addr == in_addr) && !hit_io && !hit_prefetch && !hit_readline);

    // R7
    absent_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~IMPL_MASK) == '0);

    // R8
    nohit_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> !hit_io && !hit_prefetch && !hit_readline && hit_idx == '0);
endmodule

bind addr_window_decoder awd_checker #(
    .ADDR_W   (ADDR_W),
    .PAGE_LSB (PAGE_LSB),
    .NUM_WIN  (NUM_WIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_addr      (in_addr),
    .hit_vec      (hit_vec),
    .any_hit      (any_hit),
    .hit_idx      (hit_idx),
    .hit_io       (hit_io),
    .hit_prefetch (hit_prefetch),
    .hit_readline (hit_readline),
    .out_addr     (out_addr)
);

// File: tb/sim_addr_window_decoder.sv
// Bench: behavioural reference model compared against the decoder every clock.
module sim_addr_window_decoder;
    localparam int          NW    = 4;
    localparam logic [31:0] CBASE = 32'hC000_0000;
    localparam logic [31:0] CMASK = 32'hFFFF_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_win = '0;
    logic [1:0]  wr_fld = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_win = '0;
    logic [1:0]  rd_fld = '0;
    logic [31:0] rd_data;
    logic [31:0] in_addr = '0;
    logic [5:0]  hit_vec;
    logic        any_hit;
    logic [2:0]  hit_idx;
    logic        hit_io, hit_prefetch, hit_readline;
    logic [31:0] out_addr;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string phase = "R1";

    always #2 clk = ~clk;

    addr_window_decoder #(.NUM_WIN(NW), .CFG_BASE(CBASE), .CFG_MASK(CMASK)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_fld(wr_fld),
        .wr_data(wr_data), .rd_win(rd_win), .rd_fld(rd_fld), .rd_data(rd_data),
        .in_addr(in_addr), .hit_vec(hit_vec), .any_hit(any_hit), .hit_idx(hit_idx),
        .hit_io(hit_io), .hit_prefetch(hit_prefetch), .hit_readline(hit_readline),
        .out_addr(out_addr)
    );

    // Reference model state, full 32-bit values per window
    logic [31:0] mb [6];
    logic [31:0] mm [6];
    logic [31:0] mx [6];
    logic        mio [6];
    logic [2:0]  mc [6];

    initial begin
        for (int i = 0; i < 6; i++) begin
            mb[i] = '0; mm[i] = '0; mx[i] = '0; mio[i] = 1'b0; mc[i] = '0;
        end
        mb[0] = CBASE;
        mm[0] = CMASK;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < 6; i++) begin
                mb[i] = '0; mm[i] = '0; mx[i] = '0; mio[i] = 1'b0; mc[i] = '0;
            end
        end else if (wr_en && wr_win >= 1 && int'(wr_win) < NW) begin
            case (wr_fld)
                2'd0: mc[wr_win] = wr_data[2:0];
                2'd1: begin mb[wr_win] = wr_data & 32'hFFFF_F000; mio[wr_win] = wr_data[0]; end
                2'd2: mm[wr_win] = wr_data & 32'hFFFF_F000;
                default: mx[wr_win] = wr_data & 32'hFFFF_F000;
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) %s actual=%h expected=%h", req, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        int          w = -1;
        logic [31:0] eout, erd;
        logic [5:0]  evec = '0;
        for (int i = 0; i < NW; i++)
            if (w < 0 && mm[i] != 0 && ((in_addr & mm[i]) == (mb[i] & mm[i]))) w = i;
        eout = in_addr;
        if (w >= 0) begin
            evec[w] = 1'b1;
            if (mc[w][0]) eout = (in_addr & ~mm[w]) | (mx[w] & mm[w]);
        end
        chk("R4", "hit_vec", 32'(hit_vec), 32'(evec));
        chk("R4", "any_hit", 32'(any_hit), 32'(w >= 0));
        chk("R4", "hit_idx", 32'(hit_idx), (w >= 0) ? 32'(w) : 32'd0);
        chk("R5", "out_addr", out_addr, eout);
        chk("R8", "attrs", {29'd0, hit_readline, hit_prefetch, hit_io},
            (w >= 0) ? {29'd0, mc[w][2], mc[w][1], mio[w]} : 32'd0);
        erd = '0;
        if (int'(rd_win) < NW) begin
            case (rd_fld)
                2'd0: erd = {29'd0, mc[rd_win]};
                2'd1: erd = mb[rd_win] | {31'd0, mio[rd_win]};
                2'd2: erd = mm[rd_win];
                default: erd = mx[rd_win];
            endcase
        end
        chk("R2", "rd_data", rd_data, erd);
    endtask

    // Apply one cycle of stimulus, then compare just after the next falling edge
    task automatic step(input logic we, input logic [2:0] ww, input logic [1:0] wf,
                        input logic [31:0] wd, input logic [2:0] rw, input logic [1:0] rf,
                        input logic [31:0] a);
        wr_en = we; wr_win = ww; wr_fld = wf; wr_data = wd;
        rd_win = rw; rd_fld = rf; in_addr = a;
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset programmable windows read zero; window 0 config
        phase = "R1";
        for (int f = 0; f < 4; f++) step(1'b0, 3'd0, 2'd0, '0, 3'd1, 2'(f), 32'h1234_5678);
        step(1'b0, 3'd0, 2'd0, '0, 3'd0, 2'd1, 32'hC000_0ABC);
        // R6: config window fixed, writes ignored, untranslated
        phase = "R6";
        step(1'b1, 3'd0, 2'd1, 32'h1000_0001, 3'd0, 2'd1, 32'hC000_0010);
        step(1'b1, 3'd0, 2'd0, 32'h7, 3'd0, 2'd0, 32'hC000_0FFF);
        chk("R6", "cfg out_addr", out_addr, 32'hC000_0FFF);
        chk("R6", "cfg hit_vec", 32'(hit_vec), 32'h1);
        // R9: field bit layout on readback
        phase = "R9";
        step(1'b1, 3'd1, 2'd1, 32'h1000_0FFF, 3'd1, 2'd1, 32'h0);
        chk("R9", "base readback", rd_data, 32'h1000_0001);
        step(1'b1, 3'd1, 2'd2, 32'hF000_0FFF, 3'd1, 2'd2, 32'h0);
        chk("R9", "mask readback", rd_data, 32'hF000_0000);
        step(1'b1, 3'd1, 2'd3, 32'h8000_0ABC, 3'd1, 2'd3, 32'h0);
        step(1'b1, 3'd1, 2'd0, 32'hFFFF_FFF9, 3'd1, 2'd0, 32'h0);
        chk("R9", "ctrl readback", rd_data, 32'h1);
        // R3 / R4: overlapping window 2; lowest number wins
        phase = "R4";
        step(1'b1, 3'd2, 2'd1, 32'h1000_0000, 3'd2, 2'd1, 32'h0);
        step(1'b1, 3'd2, 2'd2, 32'hFFF0_0000, 3'd2, 2'd2, 32'h0);
        step(1'b1, 3'd2, 2'd0, 32'h6, 3'd2, 2'd0, 32'h1001_2345);
        chk("R4", "priority idx", 32'(hit_idx), 32'd1);
        chk("R5", "translated", out_addr, 32'h8001_2345);
        // R3: zero-mask window 3 never hits even with matching base
        phase = "R3";
        step(1'b1, 3'd3, 2'd1, 32'h2000_0001, 3'd3, 2'd1, 32'h2000_0000);
        chk("R3", "zero mask any_hit", 32'(any_hit), 32'd0);
        step(1'b1, 3'd3, 2'd2, 32'hFFFF_F000, 3'd3, 2'd2, 32'h2000_0004);
        chk("R3", "window 3 hit", 32'(hit_vec), 32'h8);
        // R7: absent slots ignore writes and read zero
        phase = "R7";
        for (int s = 4; s < 8; s++) begin
            step(1'b1, 3'(s), 2'd2, 32'hFFFF_F000, 3'(s), 2'd2, 32'h5555_5000);
            step(1'b1, 3'(s), 2'd1, 32'h5555_5001, 3'(s), 2'd1, 32'h5555_5000);
            chk("R7", "absent readback", rd_data, 32'h0);
        end
        // R2 / R5 / R8: random traffic around programmed bases
        phase = "R2";
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a;
            int          pick = $urandom_range(0, 5);
            a = $urandom;
            if (pick < NW) a = mb[pick] ^ ($urandom & 32'h00FF_FFFF & ~mm[pick]) ^ ($urandom & 32'hFFF);
            step(($urandom_range(0, 3) == 0), 3'($urandom_range(0, 7)), 2'($urandom),
                 ($urandom_range(0, 1) == 0) ? ($urandom & 32'hFF00_0FFF) : $urandom,
                 3'($urandom_range(0, 7)), 2'($urandom), a);
        end
        // R1: reset in mid-operation clears programmable windows
        phase = "R1";
        rst_n = 1'b0;
        step(1'b0, 3'd0, 2'd0, '0, 3'd2, 2'd2, 32'h1000_0000);
        rst_n = 1'b1;
        step(1'b0, 3'd0, 2'd0, '0, 3'd1, 2'd1, 32'h1000_0000);
        chk("R1", "post reset any_hit", 32'(any_hit), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule